// File: doc/BRIEF.md
# Vector Element Issue Sequencer

The sequencer expands one scalar instruction that carries per-operand vector tags into a run of ordinary scalar micro-operations, one per vector element. It acts as a hardware loop. The front end offers a start request with a destination register number, two source register numbers, a vector length, one vector tag per operand and a predicate mask. The sequencer then holds the program counter stalled while it walks the element index from zero upward.

For each element whose predicate bit is set, the sequencer presents one scalar operation on a valid/ready output. The operation carries the element index and the three register numbers for that element. An operand tagged as vector moves to the next register on every element step. An untagged operand stays on its base register. This lets one loop cover the scalar-scalar, scalar-vector and vector-vector forms. When the last element has been issued or skipped, the stall is released and a one-cycle done pulse follows.

Top module: `vec_issue_seq`

## Requirements
- R1: A start request seen in a cycle when no sequence is running captures every operand input. The element with index 0 is presented in the cycle after the capturing edge.
- R2: Element indices are visited in order from 0 to VL-1, one step at a time. The index of the element on offer appears on `op_idx_o`.
- R3: An element is offered (`op_valid_o` high) only when bit i of `pred_mask_i` is set, where i is the element index and bit 0 is the LSB. When `pred_en_i` is low at start, the mask is treated as all ones.
- R4: The register number for an operand is its base plus its offset, modulo 2^REG_W. The offset of a vector-tagged operand equals the element index, so the offset of every operand starts at 0. An untagged operand issues its base register for every element.
- R5: A masked-off element still takes one element step and one register slot. It uses one cycle and does not wait for `op_ready_i`.
- R6: `stall_o` is high from the cycle after an accepted start with nonzero VL until the last element step. It is low in the done cycle and whenever the sequencer is idle.
- R7: While `op_valid_o` is high and `op_ready_i` is low, the offered operation, its index and its register numbers hold unchanged. The sequence advances only on a handshake.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last element is issued or skipped.
- R9: A start with VL equal to 0 issues nothing, does not stall, and raises `done_o` in the cycle after the start.
- R10: A start request that arrives while a sequence is running is ignored. The running sequence and its operands are unaffected, and no new sequence follows it.
- R11: A VL above MAX_VL (64) is clamped to MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| rd_i | input | REG_W | Destination base register |
| rs1_i | input | REG_W | First source base register |
| rs2_i | input | REG_W | Second source base register |
| rd_vec_i | input | 1 | Destination tagged as vector |
| rs1_vec_i | input | 1 | First source tagged as vector |
| rs2_vec_i | input | 1 | Second source tagged as vector |
| vl_i | input | VL_W | Vector length |
| pred_en_i | input | 1 | Predicate mask enable |
| pred_mask_i | input | MAX_VL | Predicate mask, bit i gates element i |
| op_valid_o | output | 1 | Scalar operation on offer |
| op_ready_i | input | 1 | Downstream accepts the operation |
| op_idx_o | output | IDX_W | Element index of the offer |
| op_rd_o | output | REG_W | Destination register of the offer |
| op_rs1_o | output | REG_W | First source register of the offer |
| op_rs2_o | output | REG_W | Second source register of the offer |
| stall_o | output | 1 | Program counter hold |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The first element is due one cycle after the edge that takes the start. After that, every element uses one cycle, plus one more for each cycle the downstream holds ready low against a valid offer. The done pulse is therefore due VL + waits + 1 cycles after the start edge, and the bench checks it at exactly that count. The bench drives inputs and samples outputs at the falling edge. It applies ready there as well, so it knows which rising edge completes each handshake. It checks every accepted offer against a list of active elements computed from the mask, and it checks held offers for stability on the following sample.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef enum int {
    OPND_RD  = 0,
    OPND_RS1 = 1,
    OPND_RS2 = 2
  } opnd_e;

  localparam int NUM_OPND = 3;
endpackage

// File: rtl/vis_ctrl.sv
module vis_ctrl #(
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            elem_act_i,
  input  logic            op_ready_i,
  output logic            run_o,
  output logic            load_o,
  output logic            step_o,
  output logic [VL_W-1:0] idx_o,
  output logic            done_o
);
  import vis_pkg::*;

  localparam logic [VL_W-1:0] VL_MAX_C = VL_W'(MAX_VL);
  localparam logic [VL_W-1:0] ONE_C    = VL_W'(1);

  seq_state_e      state_q;
  logic [VL_W-1:0] vl_q, idx_q, vl_clip;
  logic            last_elem;

  assign vl_clip   = (vl_i > VL_MAX_C) ? VL_MAX_C : vl_i;
  assign run_o     = (state_q == ST_RUN);
  assign load_o    = start_i && (state_q == ST_IDLE);
  // masked element advances without waiting for ready
  assign step_o    = run_o && (!elem_act_i || op_ready_i);
  assign last_elem = (idx_q == vl_q - ONE_C);
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vl_q    <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        idx_q <= '0;
        vl_q  <= vl_clip;
        if (vl_clip == '0) done_o  <= 1'b1;
        else               state_q <= ST_RUN;
      end else if (step_o) begin
        if (last_elem) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          idx_q <= idx_q + ONE_C;
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idx_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (idx_q < vl_q) && (vl_q <= VL_MAX_C));
  assert_hold_no_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !step_o) |=> run_o && $stable(idx_q));
  assert_vl_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && vl_clip == '0) |=> done_o && !run_o);
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i) |=> $stable(vl_q));
  assert_first_idx_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && vl_clip != '0) |=> run_o && idx_q == '0);
endmodule

// File: rtl/vis_pred.sv
module vis_pred #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              pred_en_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              elem_act_o
);
  logic [MAX_VL-1:0] mask_q;

  // disabled predicate loads as all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= pred_en_i ? mask_i : '1;
  end

  assign elem_act_o = mask_q[idx_i];

  assert_mask_all_ones_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pred_en_i) |=> elem_act_o);
endmodule

// File: rtl/vis_opnd.sv
module vis_opnd #(
  parameter int REG_W  = 7,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             run_i,
  input  logic [VL_W-1:0]  idx_i,
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  output logic [REG_W-1:0] reg_o
);
  localparam int SUM_W = REG_W + VL_W;

  logic [REG_W-1:0] base_q;
  logic             vec_q;
  logic [VL_W-1:0]  off_q;
  logic [SUM_W-1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vec_q  <= 1'b0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      vec_q  <= vec_i;
      off_q  <= '0;
    end else if (step_i && vec_q) begin
      off_q <= off_q + VL_W'(1);
    end
  end

  assign sum   = {{VL_W{1'b0}}, base_q} + {{REG_W{1'b0}}, off_q};
  assign reg_o = sum[REG_W-1:0];

  // offset tracks the element counter for tagged operands, also across masked steps
  assert_off_tracks_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && vec_q) |-> off_q == idx_i);
  assert_scalar_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_q |-> off_q == '0);
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq #(
  parameter int REG_W  = 7,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic [REG_W-1:0]  rs1_i,
  input  logic [REG_W-1:0]  rs2_i,
  input  logic              rd_vec_i,
  input  logic              rs1_vec_i,
  input  logic              rs2_vec_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              pred_en_i,
  input  logic [MAX_VL-1:0] pred_mask_i,
  output logic              op_valid_o,
  input  logic              op_ready_i,
  output logic [IDX_W-1:0]  op_idx_o,
  output logic [REG_W-1:0]  op_rd_o,
  output logic [REG_W-1:0]  op_rs1_o,
  output logic [REG_W-1:0]  op_rs2_o,
  output logic              stall_o,
  output logic              done_o
);
  import vis_pkg::*;

  logic                 run, load, step, elem_act;
  logic [VL_W-1:0]      idx;
  logic [REG_W-1:0]     base [NUM_OPND];
  logic                 vec  [NUM_OPND];
  logic [REG_W-1:0]     regn [NUM_OPND];

  assign base[OPND_RD]  = rd_i;
  assign base[OPND_RS1] = rs1_i;
  assign base[OPND_RS2] = rs2_i;
  assign vec[OPND_RD]   = rd_vec_i;
  assign vec[OPND_RS1]  = rs1_vec_i;
  assign vec[OPND_RS2]  = rs2_vec_i;

  vis_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .vl_i       (vl_i),
    .elem_act_i (elem_act),
    .op_ready_i (op_ready_i),
    .run_o      (run),
    .load_o     (load),
    .step_o     (step),
    .idx_o      (idx),
    .done_o     (done_o)
  );

  vis_pred #(.MAX_VL(MAX_VL)) u_pred (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .pred_en_i  (pred_en_i),
    .mask_i     (pred_mask_i),
    .idx_i      (idx[IDX_W-1:0]),
    .elem_act_o (elem_act)
  );

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    vis_opnd #(.REG_W(REG_W), .MAX_VL(MAX_VL)) u_opnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .step_i (step),
      .run_i  (run),
      .idx_i  (idx),
      .base_i (base[g]),
      .vec_i  (vec[g]),
      .reg_o  (regn[g])
    );
  end

  assign op_valid_o = run && elem_act;
  assign op_idx_o   = idx[IDX_W-1:0];
  assign op_rd_o    = regn[OPND_RD];
  assign op_rs1_o   = regn[OPND_RS1];
  assign op_rs2_o   = regn[OPND_RS2];
  assign stall_o    = run;

  assert_valid_under_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> stall_o);
  assert_done_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stall_o && !op_valid_o);
  assert_offer_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ready_i) |=> op_valid_o && $stable(op_idx_o) && $stable(op_rd_o)
      && $stable(op_rs1_o) && $stable(op_rs2_o));
endmodule

// File: tb/vec_issue_seq_tb_top.sv
`timescale 1ns/1ps
module vec_issue_seq_tb_top;
  localparam int REG_W  = 7;
  localparam int MAX_VL = 64;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int IDX_W  = $clog2(MAX_VL);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [REG_W-1:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic              rd_vec_i = 1'b0, rs1_vec_i = 1'b0, rs2_vec_i = 1'b0;
  logic [VL_W-1:0]   vl_i = '0;
  logic              pred_en_i = 1'b0;
  logic [MAX_VL-1:0] pred_mask_i = '0;
  logic              op_ready_i = 1'b0;
  logic              op_valid_o, stall_o, done_o;
  logic [IDX_W-1:0]  op_idx_o;
  logic [REG_W-1:0]  op_rd_o, op_rs1_o, op_rs2_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  vec_issue_seq #(.REG_W(REG_W), .MAX_VL(MAX_VL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .rd_i(rd_i), .rs1_i(rs1_i), .rs2_i(rs2_i),
    .rd_vec_i(rd_vec_i), .rs1_vec_i(rs1_vec_i), .rs2_vec_i(rs2_vec_i),
    .vl_i(vl_i), .pred_en_i(pred_en_i), .pred_mask_i(pred_mask_i),
    .op_valid_o(op_valid_o), .op_ready_i(op_ready_i), .op_idx_o(op_idx_o),
    .op_rd_o(op_rd_o), .op_rs1_o(op_rs1_o), .op_rs2_o(op_rs2_o),
    .stall_o(stall_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // rmode 0: ready always high; 1: ready only on even sample counts
  task automatic run_seq(input logic [REG_W-1:0] rd, input logic [REG_W-1:0] rs1,
                         input logic [REG_W-1:0] rs2, input int vl, input logic [2:0] vecs,
                         input bit pen, input logic [MAX_VL-1:0] mask,
                         input int rmode, input bit poke);
    int vlc, cnt, n, waits, got;
    bit done_seen, hold, rdy;
    int exp_e [MAX_VL];
    logic [IDX_W-1:0] h_idx;
    logic [REG_W-1:0] h_rd, h_rs1, h_rs2;
    vlc = (vl > MAX_VL) ? MAX_VL : vl;
    cnt = 0;
    for (int e = 0; e < vlc; e++)
      if (!pen || mask[e]) begin exp_e[cnt] = e; cnt++; end
    @(negedge clk);
    rd_i = rd; rs1_i = rs1; rs2_i = rs2;
    rd_vec_i = vecs[0]; rs1_vec_i = vecs[1]; rs2_vec_i = vecs[2];
    vl_i = VL_W'(vl); pred_en_i = pen; pred_mask_i = mask;
    start_i = 1'b1; op_ready_i = 1'b0;
    n = 0; waits = 0; got = 0; done_seen = 0; hold = 0;
    h_idx = '0; h_rd = '0; h_rs1 = '0; h_rs2 = '0;
    while (!done_seen && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) start_i = 1'b0;
      if (poke && n == 2) begin
        start_i = 1'b1; vl_i = VL_W'(3); rd_i = 7'd99; rs1_i = 7'd98; rs2_i = 7'd97;
        rd_vec_i = 1'b0; pred_en_i = 1'b0;
      end
      if (poke && n == 3) start_i = 1'b0;
      if (done_o) begin
        done_seen = 1;
        chk(n == vlc + waits + 1, "R8", "done sample count", n, vlc + waits + 1);
        chk(!stall_o, "R6", "stall in done cycle", stall_o, 0);
      end else begin
        chk(stall_o == (vlc != 0), "R6", "stall while running", stall_o, vlc != 0);
        if (hold) begin
          chk(op_valid_o && op_idx_o == h_idx && op_rd_o == h_rd &&
              op_rs1_o == h_rs1 && op_rs2_o == h_rs2, "R7", "held offer idx",
              op_idx_o, h_idx);
        end
        rdy = (rmode == 0) ? 1'b1 : (n % 2 == 0);
        op_ready_i = rdy;
        hold = 0;
        if (op_valid_o) begin
          if (rdy) begin
            if (got < cnt) begin
              chk(op_idx_o == IDX_W'(exp_e[got]), "R2", "element index", op_idx_o, exp_e[got]);
              chk(op_rd_o == REG_W'(rd + (vecs[0] ? exp_e[got] : 0)), "R4", "rd",
                  op_rd_o, REG_W'(rd + (vecs[0] ? exp_e[got] : 0)));
              chk(op_rs1_o == REG_W'(rs1 + (vecs[1] ? exp_e[got] : 0)), "R5", "rs1",
                  op_rs1_o, REG_W'(rs1 + (vecs[1] ? exp_e[got] : 0)));
              chk(op_rs2_o == REG_W'(rs2 + (vecs[2] ? exp_e[got] : 0)), "R4", "rs2",
                  op_rs2_o, REG_W'(rs2 + (vecs[2] ? exp_e[got] : 0)));
            end else begin
              chk(1'b0, "R3", "extra offer idx", op_idx_o, -1);
            end
            got++;
          end else begin
            waits++; hold = 1;
            h_idx = op_idx_o; h_rd = op_rd_o; h_rs1 = op_rs1_o; h_rs2 = op_rs2_o;
          end
        end
      end
    end
    chk(done_seen, "R8", "done seen", done_seen, 1);
    chk(got == cnt, "R3", "offers accepted", got, cnt);
    @(negedge clk);
    chk(!done_o, "R8", "done one cycle", done_o, 0);
    chk(!stall_o && !op_valid_o, "R10", "idle after done", stall_o, 0);
    op_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(!stall_o && !op_valid_o && !done_o, "R6", "reset outputs", stall_o, 0);
  endtask
  task automatic t_vv_all;      // R1 R2 R4
    run_seq(7'd10, 7'd20, 7'd40, 8, 3'b111, 1'b1, '1, 0, 1'b0);
  endtask
  task automatic t_mixed_mask;  // R3 R5
    run_seq(7'd5, 7'd60, 7'd30, 8, 3'b101, 1'b1, 64'hA5, 0, 1'b0);
  endtask
  task automatic t_pred_off;    // R3
    run_seq(7'd1, 7'd2, 7'd3, 5, 3'b010, 1'b0, '0, 0, 1'b0);
  endtask
  task automatic t_backpress;   // R7
    run_seq(7'd33, 7'd44, 7'd55, 6, 3'b111, 1'b1, 64'h2D, 1, 1'b0);
  endtask
  task automatic t_vl_zero;     // R9
    run_seq(7'd8, 7'd9, 7'd10, 0, 3'b111, 1'b1, '1, 0, 1'b0);
  endtask
  task automatic t_all_masked;  // R5
    run_seq(7'd8, 7'd9, 7'd10, 7, 3'b111, 1'b1, '0, 0, 1'b0);
  endtask
  task automatic t_clamp_wrap;  // R11 R4
    run_seq(7'd120, 7'd0, 7'd127, 100, 3'b011, 1'b1, 64'hF0F0_0000_FFFF_0001, 0, 1'b0);
  endtask
  task automatic t_busy_start;  // R10
    run_seq(7'd12, 7'd14, 7'd16, 6, 3'b111, 1'b1, '1, 1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_vv_all();
    t_mixed_mask();
    t_pred_off();
    t_backpress();
    t_vl_zero();
    t_all_masked();
    t_clamp_wrap();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule